// File: doc/BRIEF.md
# Dual-Width Timer with Compare

This block is a timer/counter that runs in one of two widths. In narrow mode it is an 8-bit counter with two independent compare channels, A and B. In wide mode a second counter byte joins the first to form a 16-bit counter. The two compare bytes then pair up into one 16-bit compare value: byte A is the low half and byte B is the high half. The counter moves only when an external clock-select stage sends a one-cycle count-enable pulse. With no pulse, it holds its value.

Software reaches the counter bytes, the compare bytes, a control byte, a flag byte and a mask byte through a simple write port and a combinational read port. Three events raise flags: a match on channel A, a match on channel B, and an overflow. Software clears a flag by writing a 1 to its bit. A single interrupt line is raised while any flag is set and its mask bit is also set.

The block has no streaming data path, so the register port has no valid/ready handshake. A write always takes effect in the cycle in which `wr_en` is high.

Register map (`wr_addr`/`rd_addr`): 0 = counter low byte, 1 = counter high byte, 2 = compare byte A, 3 = compare byte B, 4 = control (bit 0 = wide mode, bit 1 = TOP taken from the compare value), 5 = flags, 6 = mask. Flags and mask share one bit layout: bit 0 = match A, bit 1 = match B, bit 2 = overflow. Address 7 reads as zero.

Top module: `dual_width_timer`

## Requirements
- R1: After reset, the following all read as zero and `irq` is low: both counter bytes, both compare bytes, the control byte (so narrow mode with TOP = MAX), the flags and the mask.
- R2: The counter holds its value while `cnt_en` is low. On each `cnt_en` pulse it advances by one.
- R3: In narrow mode with TOP = MAX, a pulse while the low byte is 0xFF sets that byte to 0x00 and sets flag bit 2 (overflow).
- R4: In narrow mode with control bit 1 set, a pulse while the low byte equals compare byte A clears the low byte to 0x00 and sets flag bit 0. If byte A is below 0xFF, flag bit 2 is not set.
- R5: In narrow mode, a pulse while the low byte equals compare byte B sets flag bit 1. It has no effect on the count sequence.
- R6: In wide mode the counter is 16 bits: {high byte, low byte}. A carry out of the low byte increments the high byte. With TOP = MAX, a pulse at 0xFFFF gives 0x0000 and sets flag bit 2.
- R7: In wide mode a pulse while the 16-bit counter equals {compare B, compare A} sets flag bit 0. Flag bit 1 is never set in wide mode. With control bit 1 set, that same pulse also clears the whole counter to zero.
- R8: Writing the flag byte clears each flag whose data bit is 1 and leaves the others unchanged. If a flag is set and cleared in the same cycle, the set wins.
- R9: `irq` is high exactly when (flags AND mask) is non-zero. It follows the flag and mask registers with no extra cycle of delay.
- R10: A write to a counter byte replaces that byte in the same cycle, taking priority over a concurrent count pulse.
- R11: In narrow mode the counter high byte keeps its value through counting and wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | One-cycle count pulse from the clock-select stage |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Combinational read data |
| irq | output | 1 | Masked interrupt request |

## Verification
The state that matters most is the counter's wrap decision. If it is wrong, the counter reads back a non-zero value or a wrong high byte on the very next read after the pulse at TOP or MAX. The overflow or match flag is also missing or extra in that same cycle. Corrupted flag or mask state shows on `irq` within the cycle after the bad update, because `irq` is a plain function of those registers. The checks therefore pulse exactly across each TOP, MAX, compare and width boundary and read the result back before the next pulse.

// File: rtl/dwt_pkg.sv
package dwt_pkg;
  typedef enum logic [2:0] {
    ADR_CNT_LO = 3'd0,
    ADR_CNT_HI = 3'd1,
    ADR_CMP_A  = 3'd2,
    ADR_CMP_B  = 3'd3,
    ADR_CTRL   = 3'd4,
    ADR_FLAGS  = 3'd5,
    ADR_MASK   = 3'd6
  } dwt_addr_e;

  localparam int FLG_A   = 0;
  localparam int FLG_B   = 1;
  localparam int FLG_OVF = 2;
  localparam int NFLAGS  = 3;

  localparam int CTRL_WIDE = 0;
  localparam int CTRL_TOPA = 1;
endpackage

// File: rtl/dwt_regs.sv
module dwt_regs
  import dwt_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [BW-1:0] wr_data,
  output logic [BW-1:0] cmp_a,
  output logic [BW-1:0] cmp_b,
  output logic          wide,
  output logic          top_a,
  output logic [NFLAGS-1:0] mask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_a <= '0;
      cmp_b <= '0;
      wide  <= 1'b0;
      top_a <= 1'b0;
      mask  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_CMP_A: cmp_a <= wr_data;
        ADR_CMP_B: cmp_b <= wr_data;
        ADR_CTRL: begin
          wide  <= wr_data[CTRL_WIDE];
          top_a <= wr_data[CTRL_TOPA];
        end
        ADR_MASK: mask <= wr_data[NFLAGS-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dwt_compare.sv
module dwt_compare #(
  parameter int BW = 8,
  localparam int CW = 2 * BW
) (
  input  logic [CW-1:0] count,
  input  logic [BW-1:0] cmp_a,
  input  logic [BW-1:0] cmp_b,
  input  logic          wide,
  output logic          match_a,
  output logic          match_b
);
  logic [1:0] hit;

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    logic [CW-1:0] ref_val;
    logic          ch_on;
    if (ch == 0) begin : g_a
      // In wide mode channel A carries the joined value {B, A}
      assign ref_val = wide ? {cmp_b, cmp_a} : {count[CW-1:BW], cmp_a};
      assign ch_on   = 1'b1;
    end else begin : g_b
      assign ref_val = {count[CW-1:BW], cmp_b};
      assign ch_on   = !wide;
    end
    assign hit[ch] = ch_on && (count == ref_val);
  end

  assign match_a = hit[0];
  assign match_b = hit[1];
endmodule

// File: rtl/dwt_counter.sv
module dwt_counter #(
  parameter int BW = 8,
  localparam int CW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          wide,
  input  logic          top_a,
  input  logic          match_a,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [BW-1:0] wr_data,
  output logic [CW-1:0] count_q,
  output logic          ovf_evt
);
  logic [BW-1:0] lo_q, hi_q, lo_nx, hi_nx;
  logic          lo_max, hi_max, at_max, wrap;

  assign lo_max = &lo_q;
  assign hi_max = &hi_q;
  assign at_max = wide ? (lo_max && hi_max) : lo_max;
  assign wrap   = at_max || (top_a && match_a);

  always_comb begin
    lo_nx = lo_q + 1'b1;
    hi_nx = hi_q;
    if (wrap) begin
      lo_nx = '0;
      if (wide) hi_nx = '0;
    end else if (wide && lo_max) begin
      hi_nx = hi_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (wr_lo)       lo_q <= wr_data;
      else if (cnt_en) lo_q <= lo_nx;
      if (wr_hi)       hi_q <= wr_data;
      else if (cnt_en) hi_q <= hi_nx;
    end
  end

  assign count_q = {hi_q, lo_q};
  assign ovf_evt = cnt_en && at_max;
endmodule

// File: rtl/dwt_irq.sv
module dwt_irq #(
  parameter int NF = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_vec,
  input  logic          clr_wr,
  input  logic [NF-1:0] clr_data,
  input  logic [NF-1:0] mask,
  output logic [NF-1:0] flags_q,
  output logic          irq
);
  logic [NF-1:0] clr_vec;
  assign clr_vec = clr_wr ? clr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_vec) | set_vec;
  end

  assign irq = |(flags_q & mask);
endmodule

// File: rtl/dual_width_timer.sv
module dual_width_timer
  import dwt_pkg::*;
#(
  parameter int BW = 8,
  localparam int CW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [BW-1:0] wr_data,
  input  logic [2:0]    rd_addr,
  output logic [BW-1:0] rd_data,
  output logic          irq
);
  logic [BW-1:0]     cmp_a, cmp_b;
  logic              wide_q, top_a;
  logic [NFLAGS-1:0] mask_q, flags_q, set_vec;
  logic [CW-1:0]     count_q;
  logic              match_a, match_b, ovf_evt;

  dwt_regs #(.BW(BW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cmp_a(cmp_a), .cmp_b(cmp_b), .wide(wide_q),
    .top_a(top_a), .mask(mask_q)
  );

  dwt_compare #(.BW(BW)) u_cmp (
    .count(count_q), .cmp_a(cmp_a), .cmp_b(cmp_b), .wide(wide_q),
    .match_a(match_a), .match_b(match_b)
  );

  dwt_counter #(.BW(BW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wide(wide_q),
    .top_a(top_a), .match_a(match_a),
    .wr_lo(wr_en && wr_addr == ADR_CNT_LO),
    .wr_hi(wr_en && wr_addr == ADR_CNT_HI),
    .wr_data(wr_data), .count_q(count_q), .ovf_evt(ovf_evt)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[FLG_A]   = cnt_en && match_a;
    set_vec[FLG_B]   = cnt_en && match_b;
    set_vec[FLG_OVF] = ovf_evt;
  end

  dwt_irq #(.NF(NFLAGS)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
    .clr_wr(wr_en && wr_addr == ADR_FLAGS),
    .clr_data(wr_data[NFLAGS-1:0]), .mask(mask_q),
    .flags_q(flags_q), .irq(irq)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADR_CNT_LO: rd_data = count_q[BW-1:0];
      ADR_CNT_HI: rd_data = count_q[CW-1:BW];
      ADR_CMP_A:  rd_data = cmp_a;
      ADR_CMP_B:  rd_data = cmp_b;
      ADR_CTRL: begin
        rd_data[CTRL_WIDE] = wide_q;
        rd_data[CTRL_TOPA] = top_a;
      end
      ADR_FLAGS:  rd_data[NFLAGS-1:0] = flags_q;
      ADR_MASK:   rd_data[NFLAGS-1:0] = mask_q;
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/dwt_checker.sv
module dwt_checker #(
  parameter int BW = 8,
  localparam int CW = 2 * BW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cnt_en,
  input logic          wr_en,
  input logic [2:0]    wr_addr,
  input logic [CW-1:0] count_q,
  input logic [2:0]    flags_q,
  input logic [2:0]    mask_q,
  input logic          wide_q,
  input logic          irq
);
  logic cnt_wr;
  assign cnt_wr = wr_en && (wr_addr == 3'd0 || wr_addr == 3'd1);

  // R1: reset clears counter and flags
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (count_q == '0 && flags_q == '0));

  // R2: no pulse and no write keeps the counter
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !cnt_wr) |=> $stable(count_q));

  // R2: a pulse moves the low byte up by one or back to zero
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !cnt_wr) |=>
      (count_q[BW-1:0] == $past(count_q[BW-1:0]) + 1'b1 || count_q[BW-1:0] == '0));

  // R8: flags never rise without a count pulse
  a_r8_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> ((flags_q & ~$past(flags_q)) == '0));

  // R7: channel B stays quiet in wide mode
  a_r7_no_b_wide: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_q && $past(wide_q)) |-> !$rose(flags_q[1]));

  // R9: interrupt requires a set flag and a set mask bit
  a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags_q != '0 && mask_q != '0));
endmodule

bind dual_width_timer dwt_checker #(.BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
  .wr_addr(wr_addr), .count_q(count_q), .flags_q(flags_q),
  .mask_q(mask_q), .wide_q(wide_q), .irq(irq)
);

// File: tb/dual_width_timer_bench.sv
module dual_width_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       irq;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dual_width_timer u_dual_width_timer (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic chk_reg(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      cnt_en = 1'b1;
      @(negedge clk);
      cnt_en = 1'b0;
    end
  endtask

  task automatic pulse_wr(input logic [2:0] a, input logic [7:0] d);
    cnt_en = 1'b1; wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    cnt_en = 1'b0; wr_en = 1'b0;
  endtask

  task automatic t_reset;
    for (int a = 0; a < 7; a++) chk_reg("R1", 3'(a), 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_hold;
    repeat (5) @(negedge clk);
    chk_reg("R2 hold", 3'd0, 8'h00);
    pulse(3);
    chk_reg("R2 count", 3'd0, 8'h03);
    repeat (3) @(negedge clk);
    chk_reg("R2 hold after", 3'd0, 8'h03);
    wr(3'd5, 8'hFF);
  endtask

  task automatic t_ovf8;
    wr(3'd1, 8'h12);
    wr(3'd0, 8'hFE);
    pulse(1);
    chk_reg("R3 at max", 3'd0, 8'hFF);
    chk_reg("R3 no flag yet", 3'd5, 8'h00);
    pulse(1);
    chk_reg("R3 wrap", 3'd0, 8'h00);
    chk_reg("R3 ovf flag", 3'd5, 8'h04);
    chk_reg("R11 high byte", 3'd1, 8'h12);
  endtask

  task automatic t_w1c;
    wr(3'd5, 8'h00);
    chk_reg("R8 zero keeps", 3'd5, 8'h04);
    wr(3'd5, 8'h04);
    chk_reg("R8 one clears", 3'd5, 8'h00);
    wr(3'd0, 8'hFF);
    pulse_wr(3'd5, 8'h04);
    chk_reg("R8 set wins", 3'd5, 8'h04);
    wr(3'd5, 8'hFF);
  endtask

  task automatic t_top_a;
    wr(3'd4, 8'h02);
    wr(3'd2, 8'h05);
    wr(3'd3, 8'h03);
    wr(3'd0, 8'h00);
    wr(3'd5, 8'hFF);
    pulse(3);
    chk_reg("R5 before B", 3'd5, 8'h00);
    pulse(1);
    chk_reg("R5 count", 3'd0, 8'h04);
    chk_reg("R5 flag B", 3'd5, 8'h02);
    pulse(1);
    chk_reg("R4 at A", 3'd0, 8'h05);
    pulse(1);
    chk_reg("R4 clear", 3'd0, 8'h00);
    chk_reg("R4 flag A no ovf", 3'd5, 8'h03);
  endtask

  task automatic t_irq;
    chk("R9 no mask", {7'd0, irq}, 8'h00);
    wr(3'd6, 8'h04);
    chk("R9 other mask", {7'd0, irq}, 8'h00);
    wr(3'd6, 8'h02);
    chk("R9 masked on", {7'd0, irq}, 8'h01);
    wr(3'd5, 8'h02);
    chk("R9 after clear", {7'd0, irq}, 8'h00);
    wr(3'd6, 8'h00);
    wr(3'd5, 8'hFF);
  endtask

  task automatic t_override;
    wr(3'd4, 8'h00);
    wr(3'd0, 8'h10);
    pulse_wr(3'd0, 8'h40);
    chk_reg("R10 write wins", 3'd0, 8'h40);
  endtask

  task automatic t_wide;
    wr(3'd4, 8'h01);
    wr(3'd2, 8'h34);
    wr(3'd3, 8'h12);
    wr(3'd1, 8'h00);
    wr(3'd0, 8'hFF);
    pulse(1);
    chk_reg("R6 carry lo", 3'd0, 8'h00);
    chk_reg("R6 carry hi", 3'd1, 8'h01);
    wr(3'd1, 8'hFF);
    wr(3'd0, 8'hFF);
    wr(3'd5, 8'hFF);
    pulse(1);
    chk_reg("R6 wrap lo", 3'd0, 8'h00);
    chk_reg("R6 wrap hi", 3'd1, 8'h00);
    chk_reg("R6 ovf", 3'd5, 8'h04);
    wr(3'd5, 8'hFF);
  endtask

  task automatic t_wide_cmp;
    wr(3'd1, 8'h12);
    wr(3'd0, 8'h12);
    pulse(1);
    chk_reg("R7 no B in wide", 3'd5, 8'h00);
    wr(3'd0, 8'h33);
    pulse(1);
    chk_reg("R7 before match", 3'd5, 8'h00);
    pulse(1);
    chk_reg("R7 match", 3'd5, 8'h01);
    chk_reg("R7 free run lo", 3'd0, 8'h35);
    wr(3'd5, 8'hFF);
    wr(3'd4, 8'h03);
    wr(3'd0, 8'h34);
    pulse(1);
    chk_reg("R7 top clear lo", 3'd0, 8'h00);
    chk_reg("R7 top clear hi", 3'd1, 8'h00);
    chk_reg("R7 top flag", 3'd5, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_hold;
    t_ovf8;
    t_w1c;
    t_top_a;
    t_irq;
    t_override;
    t_wide;
    t_wide_cmp;
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(negedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule